// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block turns a host byte address into a DRAM row number and a byte offset within that row. Software describes the memory layout with one boundary byte per row. Each byte gives the running top of memory up to and including that row, counted in row-granularity units. Two further high bits per row live in shared extension bytes, and each extension byte holds the high bits for a pair of rows.

Each row's window runs from the previous row's boundary up to its own boundary. The first row starts at zero. A row whose boundary does not exceed its predecessor's has an empty window. The address is compared against every window at once, and the lowest-numbered row that contains it wins.

The offset inside the winning row is masked to that row's installed size. This makes an access past the installed size wrap back into it. Results are registered one cycle after the request strobe.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every boundary byte holds DEFAULT_BOUND and every extension field holds 0; res_valid, res_hit, res_row and res_offset are 0.
- R2: A write with cfg_sel = r, for r below NUM_ROWS, replaces row r's boundary byte with cfg_wdata. A decode presented in the cycle after the write already uses the new value.
- R3: A write with cfg_sel = 8 + p serves rows 2p and 2p+1. When cfg_nib_en[0] is set, row 2p's extension field takes cfg_wdata[1:0]. When cfg_nib_en[1] is set, row 2p+1's extension field takes cfg_wdata[5:4]. The other data bits are ignored, and a row whose nibble enable is clear keeps its field.
- R4: A row's boundary is {extension[1:0], byte[7:0]} masked to its low VALID_BITS bits.
- R5: Row 0 covers [0, B0·2^UNIT_SHIFT). Row r > 0 covers [B(r-1)·2^UNIT_SHIFT, Br·2^UNIT_SHIFT).
- R6: A row with Br ≤ B(r-1) has an empty window and never hits.
- R7: When several windows contain the address, the lowest-numbered row is reported.
- R8: On a hit, res_offset = (host_addr − row base) AND (2^(INST_LOG2[r]+UNIT_SHIFT) − 1). INST_LOG2[r] is taken from bits [4r+3:4r] of INST_LOG2.
- R9: On a miss, res_hit = 0, res_row = 0 and res_offset = 0.
- R10: res_valid is high exactly in the cycle after a cycle with host_valid high. res_hit, res_row and res_offset change only in that cycle and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register slot: rows 0..7 boundary bytes, 8..11 extension bytes |
| cfg_wdata | input | 8 | Write data |
| cfg_nib_en | input | 2 | Extension nibble enables (bit 0 even row, bit 1 odd row) |
| host_valid | input | 1 | Decode request strobe |
| host_addr | input | ADDR_W | Host byte address |
| res_valid | output | 1 | Result strobe, one cycle after host_valid |
| res_hit | output | 1 | Address falls in a row window |
| res_row | output | ROW_W | Selected row index |
| res_offset | output | ADDR_W | Row-relative offset wrapped to the installed size |

## Verification
Every decode result appears on the outputs one register stage after the request strobe. The bench therefore raises host_valid on a falling edge, drops it on the next falling edge, and compares the outputs there, after the single registering edge.

Register writes follow the same pattern. The decode placed directly after a write checks that the new layout applies from the next cycle. An idle cycle after a decode confirms that the strobe falls and that the result fields hold.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
    localparam int CFG_SEL_W  = 4;
    localparam int CFG_DATA_W = 8;
    localparam int EXT_W      = 2;
    localparam int BND_W      = CFG_DATA_W + EXT_W;
    localparam int MAX_ROWS   = 8;
    localparam logic [CFG_SEL_W-1:0] EXT_SLOT0 = 4'd8;
    localparam int EXT_ODD_POS = 4;
endpackage

// File: rtl/rowbnd_regs.sv
module rowbnd_regs
    import dram_row_pkg::*;
#(
    parameter int NUM_ROWS      = 4,
    parameter int VALID_BITS    = 9,
    parameter int DEFAULT_BOUND = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_SEL_W-1:0]              cfg_sel,
    input  logic [CFG_DATA_W-1:0]             cfg_wdata,
    input  logic [1:0]                        cfg_nib_en,
    output logic [NUM_ROWS-1:0][BND_W-1:0]    bound
);
    localparam logic [BND_W-1:0] VMASK =
        (VALID_BITS >= BND_W) ? '1 : BND_W'((1 << VALID_BITS) - 1);

    typedef struct packed {
        logic [NUM_ROWS-1:0][CFG_DATA_W-1:0] lo;
        logic [NUM_ROWS-1:0][EXT_W-1:0]      hi;
    } bnd_state_t;

    bnd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                if (cfg_sel == CFG_SEL_W'(r))
                    st_d.lo[r] = cfg_wdata;
                if ((cfg_sel == EXT_SLOT0 + CFG_SEL_W'(r / 2)) && cfg_nib_en[r % 2])
                    st_d.hi[r] = (r % 2 == 1) ? cfg_wdata[EXT_ODD_POS +: EXT_W]
                                              : cfg_wdata[0 +: EXT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                st_q.lo[r] <= CFG_DATA_W'(DEFAULT_BOUND);
                st_q.hi[r] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int r = 0; r < NUM_ROWS; r++)
            bound[r] = {st_q.hi[r], st_q.lo[r]} & VMASK;
    end

    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == '0) |=> (st_q.lo[0] == $past(cfg_wdata)))
        else $error("boundary byte write lost"); // R2

    generate
        if (NUM_ROWS >= 2) begin : g_nib
            AST_NIBBLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_sel == EXT_SLOT0 && !cfg_nib_en[1]) |=> $stable(st_q.hi[1]))
                else $error("odd extension field disturbed"); // R3
        end
    endgenerate
endmodule

// File: rtl/rowbnd_window.sv
module rowbnd_window
    import dram_row_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 20,
    parameter int INST_LOG2  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BND_W-1:0]  base_bnd,
    input  logic [BND_W-1:0]  top_bnd,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    localparam int INST_SHIFT = INST_LOG2 + UNIT_SHIFT;
    localparam logic [ADDR_W-1:0] INST_MASK =
        (INST_SHIFT >= ADDR_W) ? '1 : ((ADDR_W'(1) << INST_SHIFT) - ADDR_W'(1));

    logic [ADDR_W-1:0] addr_units, base_ext, top_ext;
    logic              open_win;

    always_comb begin
        addr_units = addr >> UNIT_SHIFT;
        base_ext   = ADDR_W'(base_bnd);
        top_ext    = ADDR_W'(top_bnd);
        open_win   = top_bnd > base_bnd;
        hit        = open_win && (addr_units >= base_ext) && (addr_units < top_ext);
        offset     = (addr - (base_ext << UNIT_SHIFT)) & INST_MASK;
    end

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (top_bnd <= base_bnd) |-> !hit)
        else $error("empty window reported a hit"); // R6
endmodule

// File: rtl/rowbnd_select.sv
module rowbnd_select #(
    parameter int NUM_ROWS = 4,
    parameter int ROW_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] req,
    output logic                any,
    output logic [ROW_W-1:0]    idx
);
    logic [NUM_ROWS-1:0] grant;

    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int r = NUM_ROWS - 1; r >= 0; r--) begin
            if (req[r]) begin
                any      = 1'b1;
                idx      = ROW_W'(r);
                grant    = '0;
                grant[r] = 1'b1;
            end
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0))
        else $error("grant not a single requester"); // R7

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (idx == '0))
        else $error("row 0 request not preferred"); // R7
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
    import dram_row_pkg::*;
#(
    parameter int NUM_ROWS      = 4,
    parameter int ADDR_W        = 32,
    parameter int UNIT_SHIFT    = 20,
    parameter int VALID_BITS    = 9,
    parameter int DEFAULT_BOUND = 2,
    parameter logic [4*NUM_ROWS-1:0] INST_LOG2 = {NUM_ROWS{4'd1}},
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_SEL_W-1:0]  cfg_sel,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic [1:0]            cfg_nib_en,
    input  logic                  host_valid,
    input  logic [ADDR_W-1:0]     host_addr,
    output logic                  res_valid,
    output logic                  res_hit,
    output logic [ROW_W-1:0]      res_row,
    output logic [ADDR_W-1:0]     res_offset
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [ROW_W-1:0]  row;
        logic [ADDR_W-1:0] offset;
    } res_t;

    logic [NUM_ROWS-1:0][BND_W-1:0]  bound;
    logic [NUM_ROWS-1:0]             row_hit;
    logic [NUM_ROWS-1:0][ADDR_W-1:0] row_off;
    logic [NUM_ROWS-1:0][ADDR_W-1:0] inst_mask;
    logic                            any_hit;
    logic [ROW_W-1:0]                win_idx;
    res_t                            res_d, res_q;

    rowbnd_regs #(
        .NUM_ROWS(NUM_ROWS), .VALID_BITS(VALID_BITS), .DEFAULT_BOUND(DEFAULT_BOUND)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_nib_en(cfg_nib_en), .bound(bound)
    );

    generate
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            localparam int LG = int'(INST_LOG2[4*r +: 4]);
            logic [BND_W-1:0] base_bnd;
            if (r == 0) begin : g_first
                assign base_bnd = '0;
            end else begin : g_next
                assign base_bnd = bound[r-1];
            end
            assign inst_mask[r] = (LG + UNIT_SHIFT >= ADDR_W) ? '1
                                : ((ADDR_W'(1) << (LG + UNIT_SHIFT)) - ADDR_W'(1));
            rowbnd_window #(
                .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT), .INST_LOG2(LG)
            ) u_win (
                .clk(clk), .rst_n(rst_n), .addr(host_addr), .base_bnd(base_bnd),
                .top_bnd(bound[r]), .hit(row_hit[r]), .offset(row_off[r])
            );
        end
    endgenerate

    rowbnd_select #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .req(row_hit), .any(any_hit), .idx(win_idx)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = host_valid;
        if (host_valid) begin
            res_d.hit    = any_hit;
            res_d.row    = any_hit ? win_idx : '0;
            res_d.offset = any_hit ? row_off[win_idx] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_hit    = res_q.hit;
    assign res_row    = res_q.row;
    assign res_offset = res_q.offset;

    AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |=> res_valid)
        else $error("result strobe missing"); // R10

    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> (!res_valid && $stable(res_row) && $stable(res_offset)))
        else $error("result changed without request"); // R10

    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_row == '0 && res_offset == '0))
        else $error("miss carries row or offset"); // R9

    AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> ((res_offset & ~inst_mask[res_row]) == '0))
        else $error("offset beyond installed size"); // R8
endmodule

// File: tb/dram_row_decoder_test.sv
module dram_row_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [1:0]  cfg_nib_en = '0;
    logic        host_valid = 1'b0;
    logic [31:0] host_addr = '0;
    logic        res_valid, res_hit;
    logic [1:0]  res_row;
    logic [31:0] res_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dram_row_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_nib_en(cfg_nib_en), .host_valid(host_valid),
        .host_addr(host_addr), .res_valid(res_valid), .res_hit(res_hit),
        .res_row(res_row), .res_offset(res_offset)
    );

    // Layout after programming: B0=2, B1=4, B2=3 (empty), B3=8, 2 MB installed per row
    localparam int NV = 9;
    localparam logic [31:0] V_ADDR [0:NV-1] = '{
        32'h0000_0100, 32'h001F_FFFF, 32'h0020_0000, 32'h0035_0000, 32'h0040_0000,
        32'h0050_0010, 32'h007F_FFFF, 32'h0080_0000, 32'hFFFF_FFFF };
    localparam logic V_HIT [0:NV-1] = '{1, 1, 1, 1, 1, 1, 1, 0, 0};
    localparam logic [1:0] V_ROW [0:NV-1] = '{0, 0, 1, 1, 3, 3, 3, 0, 0};
    localparam logic [31:0] V_OFF [0:NV-1] = '{
        32'h0000_0100, 32'h001F_FFFF, 32'h0000_0000, 32'h0015_0000, 32'h0010_0000,
        32'h0000_0010, 32'h000F_FFFF, 32'h0000_0000, 32'h0000_0000 };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] sel, input logic [7:0] d, input logic [1:0] en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_nib_en = en;
        @(negedge clk);
        cfg_we = 1'b0; cfg_nib_en = '0;
    endtask

    task automatic decode(input logic [31:0] a);
        @(negedge clk);
        host_valid = 1'b1; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic h, input logic [1:0] r,
                              input logic [31:0] o);
        check({tag, " valid"}, 32'(res_valid), 32'd1);
        check({tag, " hit"}, 32'(res_hit), 32'(h));
        check({tag, " row"}, 32'(res_row), 32'(r));
        check({tag, " offset"}, res_offset, o);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state of outputs
        check("R1 res_valid", 32'(res_valid), 32'd0);
        check("R1 res_hit", 32'(res_hit), 32'd0);
        check("R1 res_offset", res_offset, 32'd0);
        rst_n = 1'b1;

        // R1 default bounds all 2: row 0 is [0,2MB), the rest are empty (R6 equal case)
        decode(32'h0000_0100);
        expect_res("R1 default row0", 1'b1, 2'd0, 32'h100);
        decode(32'h0020_0000);
        expect_res("R6 equal bound miss", 1'b0, 2'd0, 32'h0);

        // R2 program layout, decode right after the last write
        cfg_write(4'd1, 8'd4, 2'b00);
        cfg_write(4'd2, 8'd3, 2'b00);
        cfg_write(4'd3, 8'd8, 2'b00);
        decode(32'h0050_0010);
        expect_res("R2 next-cycle effect", 1'b1, 2'd3, 32'h10);

        // Table: R5 windows, R6 empty row 2, R7 overlap priority, R8 wrap, R9 miss
        for (int i = 0; i < NV; i++) begin
            decode(V_ADDR[i]);
            expect_res($sformatf("R5/R7/R8/R9 vec%0d", i), V_HIT[i], V_ROW[i], V_OFF[i]);
        end

        // R10 idle cycle: strobe drops, fields hold last result
        @(negedge clk);
        check("R10 strobe low", 32'(res_valid), 32'd0);
        check("R10 offset held", res_offset, 32'd0);
        decode(32'h0035_0000);
        @(negedge clk);
        check("R10 row held", 32'(res_row), 32'd1);
        check("R10 offset held hit", res_offset, 32'h0015_0000);

        // R3 odd nibble only, other data bits ignored: row 3 ext = 3
        // R4 VALID_BITS=9 masks bound 0x308 to 0x108 (264 MB)
        cfg_write(4'd9, 8'hF1, 2'b10);
        decode(32'h1000_0000);
        expect_res("R4 masked bound hit", 1'b1, 2'd3, 32'h0010_0000);
        decode(32'h3000_0000);
        expect_res("R4 bit beyond mask miss", 1'b0, 2'd0, 32'h0);
        decode(32'h0050_0010);
        expect_res("R3 even nibble untouched", 1'b1, 2'd3, 32'h10);

        // R3 even nibble only: row 2 ext = 1 -> B2 = 259; row 3 field must stay 3
        cfg_write(4'd9, 8'h01, 2'b01);
        decode(32'h0050_0010);
        expect_res("R3 even nibble set", 1'b1, 2'd2, 32'h0010_0010);
        decode(32'h1040_0000);
        expect_res("R3 odd nibble kept", 1'b1, 2'd3, 32'h0010_0000);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule